// File: doc/BRIEF.md
# Packed Enable/Status Interrupt Aggregator

This block collects a small set of interrupt sources into one 32-bit control word on a simple memory-mapped bus and drives a single level-sensitive request to a parent interrupt controller. The low half of the word holds a mask bit for each source. The high half holds a sticky pending bit for each source, always sixteen positions above that source's mask bit. A rising edge on a source input latches its pending bit. Software clears pending bits by writing ones to them. Writing zeros to the pending field leaves it untouched, so the mask bits can be rewritten without losing pending events.

The request output is high while at least one source has both its pending bit and its mask bit set. It stays high until software has cleared every enabled pending bit. Three things are parameters: the word's bus address, the register position of the first source, and the number of sources. This lets one variant place its sources higher in the word, for example at bits 4 and 5 instead of starting at bit 0. Reads are registered: the read data appears on the cycle after the access.

Top module: `irq_word_ctrl`

## Requirements
- R1: After reset every mask and pending bit is 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: A rising edge on source i sets the pending bit at word bit FIRST_BIT+i+16, whether or not the source is enabled. It becomes visible one clock after the edge is sampled. A source held high does not set the bit again once it has been cleared.
- R3: A write to REG_ADDR clears each pending bit whose position in `bus_wdata` holds 1 and leaves pending bits written with 0 unchanged.
- R4: A write to REG_ADDR loads the mask bit of source i from `bus_wdata` bit FIRST_BIT+i.
- R5: `irq_o` is 1 exactly when some source has both its pending bit and its mask bit set. Clearing a mask bit does not clear the pending bit.
- R6: When a rising edge and a write-one clear reach the same pending bit in the same cycle, the bit ends up set.
- R7: Word bits outside the configured mask and pending ranges read as 0 and ignore writes.
- R8: Bus writes to any address other than REG_ADDR leave the word unchanged. Reads of any other address return 0.
- R9: A read of REG_ADDR returns the current word one cycle after the access and changes no bit of it.
- R10: With FIRST_BIT=4 and NUM_SRC=2, source 0 uses mask bit 4 and pending bit 20, and source 1 uses mask bit 5 and pending bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Source event lines, synchronous to clk, rising-edge triggered |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level request to the parent controller |

## Verification
The bench builds two instances side by side on one shared bus. The first uses the defaults: seven sources from bit 0, at address 0x018. The second has two sources starting at bit 4, at address 0x570. Because the bus is shared, each instance sees the other's accesses as foreign-address traffic, which exercises R8 in both directions. The offset instance is the only one that can catch a mapping that silently assumes sources begin at bit 0. The default instance's unused bits 7..15 and 23..31 give the ignored-bit checks something to hit.

// File: rtl/irq_word_pkg.sv
package irq_word_pkg;
  localparam int WORD_W   = 32;
  localparam int STAT_OFS = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/irq_slot.sv
module irq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic wr_i,
  input  logic wen_i,
  input  logic wclr_i,
  output logic en_o,
  output logic st_o
);
  logic en_q, en_d, en_ce;
  logic st_q, st_d, st_ce;

  always_comb begin
    en_ce = wr_i;
    en_d  = wen_i;
    st_ce = rise_i | (wr_i & wclr_i);
    st_d  = rise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 1'b0;
    else if (st_ce) st_q <= st_d;
  end

  assign en_o = en_q;
  assign st_o = st_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> st_o);
  // R3
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wclr_i && !rise_i) |=> !st_o);
  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wen_i)));
  // R2
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !(wr_i && wclr_i)) |=> $stable(st_o));
endmodule

// File: rtl/irq_word_ctrl.sv
module irq_word_ctrl
  import irq_word_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h0018,
  parameter int                FIRST_BIT = 0,
  parameter int                NUM_SRC   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int STAT_BASE = FIRST_BIT + STAT_OFS;

  logic               rst_s;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] st;
  logic               hit, wr_hit, rd_acc, any_rise;
  word_t              word;
  word_t              rd_q, rd_d;
  logic               rd_ce;
  logic               unused_wdata;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_s)
  );

  irq_src_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_s), .src_i(src_i), .rise_o(rise)
  );

  always_comb begin
    hit      = bus_sel & (bus_addr == REG_ADDR);
    wr_hit   = hit & bus_wr;
    rd_acc   = bus_sel & ~bus_wr;
    any_rise = |rise;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    irq_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_s),
      .rise_i (rise[i]),
      .wr_i   (wr_hit),
      .wen_i  (bus_wdata[FIRST_BIT+i]),
      .wclr_i (bus_wdata[STAT_BASE+i]),
      .en_o   (en[i]),
      .st_o   (st[i])
    );
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      word[FIRST_BIT+i] = en[i];
      word[STAT_BASE+i] = st[i];
    end
  end

  always_comb begin
    rd_ce = rd_acc;
    rd_d  = hit ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     rd_q <= '0;
    else if (rd_ce) rd_q <= rd_d;
  end

  assign bus_rdata    = rd_q;
  assign irq_o        = |(en & st);
  assign unused_wdata = ^bus_wdata;

  // R8
  miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && (bus_addr != REG_ADDR) && !any_rise) |=> $stable(word));
  // R9
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && !bus_wr && !any_rise) |=> $stable(word));
  // R9
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && !bus_wr && (bus_addr == REG_ADDR)) |=> (bus_rdata == $past(word)));
endmodule

// File: tb/irq_word_ctrl_tb_top.sv
module irq_word_ctrl_tb_top;
  typedef struct {
    bit          inst;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  src_a;
  logic [1:0]  src_b;
  logic        bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  irq_word_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_a), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_o(irq_a)
  );

  irq_word_ctrl #(.ADDR_W(16), .REG_ADDR(16'h0570), .FIRST_BIT(4), .NUM_SRC(2)) dut_b (
    .clk(clk), .rst_n(rst_n), .src_i(src_b), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_o(irq_b)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(bit inst, logic [15:0] a, logic [31:0] exp, string req);
    sb_item_t it;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.inst = inst; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    bus_sel = 0;
  endtask

  // monitor: the read data register loads at the edge after the read strobe
  always begin
    @(posedge clk);
    #2;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.req, it.inst ? rdata_b : rdata_a, it.exp);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; src_a = '0; src_b = '0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_a", {31'd0, irq_a}, 32'd0);
    chk("R1 irq_b", {31'd0, irq_b}, 32'd0);
    chk("R1 rdata", rdata_a, 32'd0);
    rd(0, 16'h0018, 32'h0000_0000, "R1 word");

    // R2 edge latches while masked; R5 no request while masked
    @(negedge clk); src_a[2] = 1;
    @(negedge clk);
    rd(0, 16'h0018, 32'h0004_0000, "R2 latch masked");
    chk("R5 masked no irq", {31'd0, irq_a}, 32'd0);

    // R4 enable load, zero status write keeps pending (R3)
    wr(16'h0018, 32'h0000_0004);
    rd(0, 16'h0018, 32'h0004_0004, "R4 enable with R3 zero write");
    chk("R5 irq on", {31'd0, irq_a}, 32'd1);

    // R7 out-of-range bits ignored
    wr(16'h0018, 32'hFF80_FF84);
    rd(0, 16'h0018, 32'h0004_0004, "R7 unused bits");

    // R3 clear by one
    wr(16'h0018, 32'h0004_0004);
    rd(0, 16'h0018, 32'h0000_0004, "R3 clear");
    chk("R3 irq off", {31'd0, irq_a}, 32'd0);
    // R2 level held high does not re-set
    repeat (2) @(negedge clk);
    rd(0, 16'h0018, 32'h0000_0004, "R2 held level");
    src_a[2] = 0;

    // R5 level until all enabled pending cleared
    @(negedge clk); src_a[0] = 1; src_a[3] = 1;
    @(negedge clk); src_a[0] = 0; src_a[3] = 0;
    chk("R5 other masked", {31'd0, irq_a}, 32'd0);
    rd(0, 16'h0018, 32'h0009_0004, "R2 two sources");
    wr(16'h0018, 32'h0000_0009);
    chk("R5 two pending", {31'd0, irq_a}, 32'd1);
    wr(16'h0018, 32'h0001_0009);
    chk("R5 one left", {31'd0, irq_a}, 32'd1);
    wr(16'h0018, 32'h0008_0009);
    chk("R5 all cleared", {31'd0, irq_a}, 32'd0);
    // R5 masking keeps pending
    @(negedge clk); src_a[0] = 1;
    @(negedge clk); src_a[0] = 0;
    wr(16'h0018, 32'h0000_0008);
    chk("R5 masked after pend", {31'd0, irq_a}, 32'd0);
    rd(0, 16'h0018, 32'h0001_0008, "R5 mask keeps pending");
    wr(16'h0018, 32'h0001_0009);

    // R6 set wins over clear
    @(negedge clk);
    src_a[1] = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 16'h0018; bus_wdata = 32'h0002_0009;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; src_a[1] = 0;
    rd(0, 16'h0018, 32'h0002_0009, "R6 set wins");

    // R8 foreign address
    wr(16'h001C, 32'hFFFF_FFFF);
    rd(0, 16'h0018, 32'h0002_0009, "R8 foreign write");
    rd(0, 16'h001C, 32'h0000_0000, "R8 foreign read");
    // R9 repeated reads identical
    rd(0, 16'h0018, 32'h0002_0009, "R9 read one");
    rd(0, 16'h0018, 32'h0002_0009, "R9 read two");

    // R10 offset variant
    @(negedge clk); src_b[0] = 1;
    @(negedge clk); src_b[0] = 0;
    rd(1, 16'h0570, 32'h0010_0000, "R10 source 0 pending");
    wr(16'h0570, 32'h0000_00FF);
    rd(1, 16'h0570, 32'h0010_0030, "R10 mask bits");
    chk("R10 irq_b", {31'd0, irq_b}, 32'd1);
    rd(0, 16'h0018, 32'h0002_0009, "R8 other instance untouched");
    @(negedge clk); src_b[1] = 1;
    @(negedge clk); src_b[1] = 0;
    rd(1, 16'h0570, 32'h0030_0030, "R10 source 1 pending");
    wr(16'h0570, 32'h0030_0030);
    rd(1, 16'h0570, 32'h0000_0030, "R10 clear");
    chk("R10 irq_b off", {31'd0, irq_b}, 32'd0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule